// File: doc/BRIEF.md
# Conditional FP-Move Predicate Evaluator

This block decides whether a conditional quad-precision floating-point move goes ahead. A request strobe presents the instruction word, the floating-point status register, the two integer condition-code nibbles and a 64-bit integer register value. A family-select input says which predicate family applies:

- a floating-point condition code taken from the status register,
- a 32-bit or 64-bit integer condition-code set, or
- a signed comparison of the register value against zero.

The block evaluates the predicate and registers the decision, which is valid one cycle after the strobe.

When the predicate is false, the move acts as a no-op. The block raises a skip pulse. The surrounding pipeline uses it to clear the current-exception field, load the PC from the next-PC, and advance the next-PC by 4. When the predicate is true, the block hands back the instruction rewritten as an unconditional quad move. The destination and second-source register fields are kept in that rewrite.

Top module: `fmov_pred_eval`

## Requirements
- R1: valid_o is 1 exactly one cycle after a cycle with req_i high and 0 otherwise. take_o and move_insn_o keep their last value while no request is made.
- R2: family_i selects the predicate family: 0 floating-point condition, 1 integer condition codes, 2 register against zero, 3 always false (skip).
- R3: For the floating-point family, insn_i[12:11]==0 selects fsr_i[11:10] as the 2-bit condition code. Values 1, 2 and 3 select fsr_i[33:32], fsr_i[35:34] and fsr_i[37:36] respectively.
- R4: Floating-point tests, chosen by insn_i[16:14] from 0 to 7, with code 0 = equal, 1 = less, 2 = greater, 3 = unordered: never; code≠0; code is 1 or 2; code bit 0 set; code==1; code bit 1 set; code==2; code==3.
- R5: For the floating-point and integer families, insn_i[17]=1 inverts the test result.
- R6: For the integer family, insn_i[12]=1 selects ccr_i[7:4] and 0 selects ccr_i[3:0]. Within the nibble, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R7: Integer tests, chosen by insn_i[16:14] from 0 to 7: never; Z; Z or (N xor V); N xor V; C or Z; C; N; V.
- R8: For the register family, insn_i[11:10] chooses the test on the signed 64-bit value: 0 never, 1 equal to zero, 2 less than or equal to zero, 3 less than zero. insn_i[12]=1 inverts the result.
- R9: skip_o is 1 exactly when valid_o is 1 and take_o is 0.
- R10: With valid_o and take_o both 1, move_insn_o equals (request insn_i AND 0x3E00001F) OR 0x81A00060. So bits 29:25 and 4:0 are copied and all other bits are fixed.
- R11: After reset, valid_o, take_o and skip_o are 0 and move_insn_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Evaluate strobe |
| family_i | input | 2 | Predicate family select |
| insn_i | input | 32 | Instruction word |
| fsr_i | input | 64 | Floating-point status register |
| ccr_i | input | 8 | Integer condition codes, {64-bit set, 32-bit set} |
| reg_val_i | input | 64 | Integer register value for the zero test |
| valid_o | output | 1 | Decision valid |
| take_o | output | 1 | Predicate true, move executes |
| skip_o | output | 1 | Predicate false: clear current exceptions and advance PC |
| move_insn_o | output | 32 | Rewritten unconditional move instruction |

## Verification
The sweep covers every test selector and its inversion against every condition code in each of the four status-register fields. While it does so, the three fields that are not selected hold the complement of the chosen one. A design that read the wrong field, or swapped the less and greater codes, would then invert decisions.

Every flag nibble is tried with both integer sets, and the set that is not selected holds the complement. This exposes a swapped set select or a wrong N xor V term.

The register test uses zero, ±1, and the most positive and most negative 64-bit values. An unsigned compare would misjudge the negative values, and an off-by-one boundary would misjudge zero.

Family 3, idle cycles and the rewritten instruction are checked as well. This catches a stuck valid, a lost hold, or corrupted register fields in the rewrite.

// File: rtl/fmov_pred_pkg.sv
package fmov_pred_pkg;

  typedef enum logic [1:0] {
    FAM_FCC  = 2'd0,
    FAM_ICC  = 2'd1,
    FAM_RZ   = 2'd2,
    FAM_NONE = 2'd3
  } pred_family_e;

  localparam int unsigned INSN_W      = 32;
  localparam int unsigned CC_NIB_W    = 4;
  localparam int unsigned FCC_FIELDS  = 4;
  localparam int unsigned FCC_W       = 2;
  localparam int unsigned FCC0_LSB    = 10;
  localparam int unsigned FCCX_BASE   = 30;
  localparam int unsigned TEST_LSB    = 14;
  localparam int unsigned TEST_W      = 3;
  localparam int unsigned INV_BIT     = 17;
  localparam int unsigned FSEL_LSB    = 11;
  localparam int unsigned ISEL_BIT    = 12;
  localparam int unsigned RZ_TEST_LSB = 10;
  localparam int unsigned RZ_INV_BIT  = 12;

  localparam logic [INSN_W-1:0] MOVE_KEEP_MASK = 32'h3E00_001F;
  localparam logic [INSN_W-1:0] MOVE_FIXED     = 32'h81A0_0060;

endpackage

// File: rtl/fcc_pred.sv
module fcc_pred
  import fmov_pred_pkg::*;
#(
  parameter int unsigned STAT_W = 64
) (
  input  logic [1:0]        field_sel_i,
  input  logic [TEST_W-1:0] test_i,
  input  logic              inv_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              hit_o
);

  logic [FCC_W-1:0] field [FCC_FIELDS];
  logic [FCC_W-1:0] code;
  logic             raw;
  logic             unused_stat;

  assign field[0] = stat_i[FCC0_LSB +: FCC_W];

  genvar g;
  generate
    for (g = 1; g < FCC_FIELDS; g++) begin : g_fld
      assign field[g] = stat_i[FCCX_BASE + FCC_W*g +: FCC_W];
    end
  endgenerate

  assign unused_stat = ^stat_i;
  assign code        = field[field_sel_i];

  always_comb begin
    unique case (test_i)
      3'd0:    raw = 1'b0;
      3'd1:    raw = (code != 2'd0);
      3'd2:    raw = (code == 2'd1) || (code == 2'd2);
      3'd3:    raw = code[0];
      3'd4:    raw = (code == 2'd1);
      3'd5:    raw = code[1];
      3'd6:    raw = (code == 2'd2);
      default: raw = (code == 2'd3);
    endcase
  end

  assign hit_o = raw ^ inv_i;

endmodule

// File: rtl/icc_pred.sv
module icc_pred
  import fmov_pred_pkg::*;
(
  input  logic                  wide_sel_i,
  input  logic [TEST_W-1:0]     test_i,
  input  logic                  inv_i,
  input  logic [2*CC_NIB_W-1:0] ccr_i,
  output logic                  hit_o
);

  logic [CC_NIB_W-1:0] nib;
  logic                f_n, f_z, f_v, f_c, lt;
  logic                raw;

  assign nib = wide_sel_i ? ccr_i[CC_NIB_W +: CC_NIB_W] : ccr_i[0 +: CC_NIB_W];
  assign f_n = nib[3];
  assign f_z = nib[2];
  assign f_v = nib[1];
  assign f_c = nib[0];
  assign lt  = f_n ^ f_v;

  always_comb begin
    unique case (test_i)
      3'd0:    raw = 1'b0;
      3'd1:    raw = f_z;
      3'd2:    raw = f_z | lt;
      3'd3:    raw = lt;
      3'd4:    raw = f_c | f_z;
      3'd5:    raw = f_c;
      3'd6:    raw = f_n;
      default: raw = f_v;
    endcase
  end

  assign hit_o = raw ^ inv_i;

endmodule

// File: rtl/rz_pred.sv
module rz_pred #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [1:0]        test_i,
  input  logic              inv_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              hit_o
);

  logic is_zero, is_neg, raw;

  assign is_zero = (val_i == '0);
  assign is_neg  = val_i[DATA_W-1];

  always_comb begin
    unique case (test_i)
      2'd0:    raw = 1'b0;
      2'd1:    raw = is_zero;
      2'd2:    raw = is_zero | is_neg;
      default: raw = is_neg;
    endcase
  end

  assign hit_o = raw ^ inv_i;

endmodule

// File: rtl/fmov_pred_eval.sv
module fmov_pred_eval
  import fmov_pred_pkg::*;
#(
  parameter int unsigned STAT_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        family_i,
  input  logic [31:0]       insn_i,
  input  logic [STAT_W-1:0] fsr_i,
  input  logic [7:0]        ccr_i,
  input  logic [DATA_W-1:0] reg_val_i,
  output logic              valid_o,
  output logic              take_o,
  output logic              skip_o,
  output logic [31:0]       move_insn_o
);

  // reset synchroniser: assert async, release on clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // predicate units
  logic fcc_hit, icc_hit, rz_hit;

  fcc_pred #(.STAT_W(STAT_W)) u_fcc (
    .field_sel_i (insn_i[FSEL_LSB +: 2]),
    .test_i      (insn_i[TEST_LSB +: TEST_W]),
    .inv_i       (insn_i[INV_BIT]),
    .stat_i      (fsr_i),
    .hit_o       (fcc_hit)
  );

  icc_pred u_icc (
    .wide_sel_i (insn_i[ISEL_BIT]),
    .test_i     (insn_i[TEST_LSB +: TEST_W]),
    .inv_i      (insn_i[INV_BIT]),
    .ccr_i      (ccr_i),
    .hit_o      (icc_hit)
  );

  rz_pred #(.DATA_W(DATA_W)) u_rz (
    .test_i (insn_i[RZ_TEST_LSB +: 2]),
    .inv_i  (insn_i[RZ_INV_BIT]),
    .val_i  (reg_val_i),
    .hit_o  (rz_hit)
  );

  // next-state
  pred_family_e fam;
  logic         take_d, valid_d, take_q, valid_q;
  logic [31:0]  insn_d, insn_q;
  logic         unused_insn;

  assign fam         = pred_family_e'(family_i);
  assign unused_insn = ^insn_i;

  always_comb begin
    unique case (fam)
      FAM_FCC: take_d = fcc_hit;
      FAM_ICC: take_d = icc_hit;
      FAM_RZ:  take_d = rz_hit;
      default: take_d = 1'b0;
    endcase
    valid_d = req_i;
    insn_d  = (insn_i & MOVE_KEEP_MASK) | MOVE_FIXED;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      take_q  <= 1'b0;
      insn_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (req_i) begin
        take_q <= take_d;
        insn_q <= insn_d;
      end
    end
  end

  assign valid_o     = valid_q;
  assign take_o      = take_q;
  assign skip_o      = valid_q & ~take_q;
  assign move_insn_o = insn_q;

endmodule

// File: rtl/fmov_pred_chk.sv
module fmov_pred_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic [1:0]  family_i,
  input logic [31:0] insn_i,
  input logic        valid_o,
  input logic        take_o,
  input logic        skip_o,
  input logic [31:0] move_insn_o
);

  // R1
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);

  // R1
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!valid_o && $stable(take_o) && $stable(move_insn_o)));

  // R9
  skip_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> (valid_o && !take_o));

  // R2
  family_none_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && family_i == 2'd3) |=> skip_o);

  // R4
  fcc_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && family_i == 2'd0 && insn_i[17:14] == 4'd0) |=> !take_o);

  // R8
  rz_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && family_i == 2'd2 && insn_i[12:10] == 3'd0) |=> !take_o);

  // R10
  move_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (move_insn_o[29:25] == $past(insn_i[29:25]) &&
               move_insn_o[4:0] == $past(insn_i[4:0]) &&
               move_insn_o[31:30] == 2'b10 && move_insn_o[24:5] == 20'hD0003));

endmodule

bind fmov_pred_eval fmov_pred_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_i       (req_i),
  .family_i    (family_i),
  .insn_i      (insn_i),
  .valid_o     (valid_o),
  .take_o      (take_o),
  .skip_o      (skip_o),
  .move_insn_o (move_insn_o)
);

// File: tb/tb_fmov_pred_eval.sv
`timescale 1ns/1ps
module tb_fmov_pred_eval;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [1:0]  family_i;
  logic [31:0] insn_i;
  logic [63:0] fsr_i;
  logic [7:0]  ccr_i;
  logic [63:0] reg_val_i;
  logic        valid_o, take_o, skip_o;
  logic [31:0] move_insn_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fmov_pred_eval dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .family_i(family_i),
    .insn_i(insn_i), .fsr_i(fsr_i), .ccr_i(ccr_i), .reg_val_i(reg_val_i),
    .valid_o(valid_o), .take_o(take_o), .skip_o(skip_o), .move_insn_o(move_insn_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_fp(input int test, input int code);
    case (test)
      0: return 0;
      1: return code != 0;
      2: return code == 1 || code == 2;
      3: return (code % 2) == 1;
      4: return code == 1;
      5: return code >= 2;
      6: return code == 2;
      default: return code == 3;
    endcase
  endfunction

  function automatic bit exp_int(input int test, input int nib);
    bit n, z, v, c;
    n = nib[3]; z = nib[2]; v = nib[1]; c = nib[0];
    case (test)
      0: return 0;
      1: return z;
      2: return z || (n != v);
      3: return n != v;
      4: return c || z;
      5: return c;
      6: return n;
      default: return v;
    endcase
  endfunction

  function automatic bit exp_reg(input int test, input longint val);
    case (test)
      0: return 0;
      1: return val == 0;
      2: return val <= 0;
      default: return val < 0;
    endcase
  endfunction

  // one request, checked on the following negedge
  task automatic run(input logic [1:0] fam, input logic [31:0] insn, input logic [63:0] fsr,
                     input logic [7:0] ccr, input logic [63:0] rv, input bit exp_take,
                     input string req);
    logic [31:0] exp_insn;
    @(negedge clk);
    family_i = fam; insn_i = insn; fsr_i = fsr; ccr_i = ccr; reg_val_i = rv; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    exp_insn = (insn & 32'h3E00001F) | 32'h81A00060;
    check(valid_o === 1'b1, "R1 valid", valid_o, 1);
    check(take_o === exp_take, req, take_o, exp_take);
    check(skip_o === !exp_take, "R9 skip", skip_o, !exp_take);
    if (exp_take) check(move_insn_o === exp_insn, "R10 rewrite", move_insn_o, exp_insn);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] insn;
    logic [63:0] fsr;
    logic [31:0] hold_insn;
    bit          hold_take;
    longint      vals [7];
    rst_n = 1'b0; req_i = 1'b0; family_i = 2'd0; insn_i = '0;
    fsr_i = '0; ccr_i = '0; reg_val_i = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(valid_o === 1'b0 && take_o === 1'b0 && skip_o === 1'b0, "R11 flags",
          {valid_o, take_o, skip_o}, 0);
    check(move_insn_o === 32'h0, "R11 insn", move_insn_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5: all fields, codes, tests, inversion
    for (int sel = 0; sel < 4; sel++)
      for (int code = 0; code < 4; code++)
        for (int cond = 0; cond < 16; cond++) begin
          fsr = 64'hDEAD_BEEF_1234_5678;
          fsr[11:10] = 2'(~code); fsr[33:32] = 2'(~code);
          fsr[35:34] = 2'(~code); fsr[37:36] = 2'(~code);
          case (sel)
            0: fsr[11:10] = 2'(code);
            1: fsr[33:32] = 2'(code);
            2: fsr[35:34] = 2'(code);
            default: fsr[37:36] = 2'(code);
          endcase
          insn = 32'hA5C3_0F1E ^ 32'(cond * 32'h0202_0001);
          insn[17:14] = 4'(cond); insn[12:11] = 2'(sel);
          run(2'd0, insn, fsr, 8'h5A, 64'd0,
              exp_fp(cond % 8, code) ^ (cond >= 8), "R3 R4 R5 fp take");
        end

    // R6 R7 R5: both sets, every flag nibble, tests, inversion
    for (int wide = 0; wide < 2; wide++)
      for (int nib = 0; nib < 16; nib++)
        for (int cond = 0; cond < 16; cond++) begin
          insn = 32'h3C5A_A5C3 ^ 32'(nib * 32'h0400_0003);
          insn[17:14] = 4'(cond); insn[12] = 1'(wide);
          run(2'd1, insn, 64'hFFFF_FFFF_FFFF_FFFF,
              wide ? {4'(nib), 4'(~nib)} : {4'(~nib), 4'(nib)}, 64'd0,
              exp_int(cond % 8, nib) ^ (cond >= 8), "R6 R7 int take");
        end

    // R8: signed zero tests with inversion
    vals = '{0, 1, -1, 64'sh7FFF_FFFF_FFFF_FFFF, 64'sh8000_0000_0000_0000, 37, -37};
    for (int vi = 0; vi < 7; vi++)
      for (int cond = 0; cond < 8; cond++) begin
        insn = 32'h1F00_001F;
        insn[12:10] = 3'(cond);
        insn[17:14] = 4'hF;
        run(2'd2, insn, '0, 8'hFF, vals[vi],
            exp_reg(cond % 4, vals[vi]) ^ (cond >= 4), "R8 reg take");
      end

    // R2: family 3 always skips, even with inverted conditions
    for (int cond = 0; cond < 16; cond++) begin
      insn = 32'hFFFF_FFFF;
      insn[17:14] = 4'(cond);
      run(2'd3, insn, '1, 8'hFF, 64'd0, 1'b0, "R2 family3");
    end

    // R1: hold with no request, inputs changing
    run(2'd1, 32'h0004_4000, '0, 8'h04, 64'd0, 1'b1, "R7 equal");
    hold_insn = move_insn_o; hold_take = take_o;
    @(negedge clk);
    family_i = 2'd3; insn_i = 32'h0; req_i = 1'b0;
    repeat (2) @(negedge clk);
    check(valid_o === 1'b0, "R1 idle valid", valid_o, 0);
    check(take_o === hold_take && move_insn_o === hold_insn, "R1 hold",
          {take_o, move_insn_o}, {hold_take, hold_insn});
    check(skip_o === 1'b0, "R9 idle skip", skip_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule